// File: doc/BRIEF.md
# Raster Timing Generator with Shadowed Cumulative Boundaries

The block produces the raster timing for a parallel RGB panel. A pixel counter runs across each line and a line counter steps once per line. Three panel strobes are decoded from the two counters: horizontal sync, vertical sync and data enable. Each strobe has its own polarity bit. The block also brings out the current pixel and line position and a one-cycle line-position interrupt. A flag that mirrors the pixel-clock inversion bit is output for the clock logic outside the block.

Software writes the timing as running boundaries rather than as individual porch widths. For each axis the boundaries are: the sync length minus one, then that value plus the back porch, then plus the active size, then plus the front porch. These values go into a shadow set. They reach the live set only when a reload is requested, either at once or at the next frame wrap. A frame can therefore be retimed without tearing.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, and after it is released, both counters read zero, `reload_pending` and `line_irq` are low, `de`, `hsync` and `vsync` sit high (every polarity bit clears to active-low, so the inactive level is high), and `pclk_inv` is low.
- R2: When enabled, `pos_x` steps by one each cycle. When `pos_x` is at or above the live horizontal total, it returns to 0 on the next cycle, and in that same cycle `pos_y` steps by one, or returns to 0 if it is at or above the live vertical total.
- R3: The active phase of `hsync` lasts while `pos_x` is at or below the live horizontal sync boundary. The active phase of `vsync` lasts while `pos_y` is at or below the live vertical sync boundary.
- R4: The active phase of `de` lasts only while `pos_x` is above the horizontal back-porch boundary and at or below the horizontal active boundary, and `pos_y` is above the vertical back-porch boundary and at or below the vertical active boundary.
- R5: Control register (address 4) bits 31, 30 and 29 select active-high for `hsync`, `vsync` and `de` respectively; a clear bit selects active-low. Bit 28 is driven on `pclk_inv`.
- R6: Control bit 0 enables the block. While it is clear, both counters are held at zero, every strobe sits at its inactive level and `line_irq` stays low.
- R7: Writes to the four timing registers (addresses 0 to 3) change only the shadow set. The counters and strobes keep using the live set until a reload occurs.
- R8: Writing reload register (address 5) with bit 0 set raises `reload_pending` on the next cycle. The shadow set is copied into the live set at the clock edge after that, and `reload_pending` then clears by itself.
- R9: Writing address 5 with bit 1 set holds `reload_pending` high until the clock edge at which both counters wrap (the frame wrap). The copy happens at that edge, and the bit clears there.
- R10: `line_irq` is high for the cycle in which the block is enabled, `pos_x` is 0 and `pos_y` equals the line-position register (address 6, bits 10:0).
- R11: Each timing register carries its horizontal value in bits 27:16 and its vertical value in bits 10:0. Address 0 holds the sync boundaries, address 1 the back-porch boundaries, address 2 the active boundaries and address 3 the totals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity-adjusted |
| vsync | output | 1 | Vertical sync, polarity-adjusted |
| de | output | 1 | Data enable, polarity-adjusted |
| pclk_inv | output | 1 | Pixel-clock inversion request |
| pos_x | output | 12 | Current pixel counter |
| pos_y | output | 11 | Current line counter |
| line_irq | output | 1 | Line-position interrupt pulse |
| reload_pending | output | 1 | A shadow reload is waiting |

## Verification
Every output is decoded from registered state, so it reflects a write, an enable change or a counter step exactly one clock edge after that edge. The one exception is an immediate reload, whose effect on the strobes lands two edges after the write edge: one edge to raise the pending bit and one to copy. A frame-wrap reload lands at the edge where both counters return to zero. The bench drives inputs on the falling edge. It advances a reference model of the requirements on each rising edge and compares every output against that model on the following falling edge. This keeps each check in the cycle where its result is due. Directed checks count these edges explicitly for the reload and enable cases.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int H_BITS    = 12;
  parameter int V_BITS    = 11;
  parameter int H_LSB     = 16;
  parameter int V_LSB     = 0;
  parameter int ADDR_BITS = 3;
  parameter int DATA_BITS = 32;

  localparam int V_PAD = H_BITS - V_BITS;

  typedef enum logic [ADDR_BITS-1:0] {
    SEL_SYNC   = 3'd0,
    SEL_BPORCH = 3'd1,
    SEL_ACTIVE = 3'd2,
    SEL_TOTAL  = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_RELOAD = 3'd5,
    SEL_LINE   = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic [H_BITS-1:0] h_sync;
    logic [H_BITS-1:0] h_bp;
    logic [H_BITS-1:0] h_act;
    logic [H_BITS-1:0] h_tot;
    logic [V_BITS-1:0] v_sync;
    logic [V_BITS-1:0] v_bp;
    logic [V_BITS-1:0] v_act;
    logic [V_BITS-1:0] v_tot;
  } timing_t;

  function automatic logic [H_BITS-1:0] h_field(input logic [DATA_BITS-1:0] d);
    return d[H_LSB +: H_BITS];
  endfunction

  function automatic logic [V_BITS-1:0] v_field(input logic [DATA_BITS-1:0] d);
    return d[V_LSB +: V_BITS];
  endfunction

  function automatic logic [H_BITS-1:0] widen_v(input logic [V_BITS-1:0] v);
    return {{V_PAD{1'b0}}, v};
  endfunction

  // strictly past the low boundary, up to and including the high one
  function automatic logic in_span(input logic [H_BITS-1:0] pos,
                                   input logic [H_BITS-1:0] lo,
                                   input logic [H_BITS-1:0] hi);
    return (pos > lo) && (pos <= hi);
  endfunction

  function automatic logic pin_level(input logic active, input logic high_true);
    return high_true ? active : ~active;
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 frame_wrap,
  output timing_t              live_tim,
  output logic                 enable,
  output logic                 pol_h,
  output logic                 pol_v,
  output logic                 pol_de,
  output logic                 pclk_flip,
  output logic [V_BITS-1:0]    line_pos,
  output logic                 pending
);
  timing_t shd_q;
  timing_t live_q;
  logic    imm_q;
  logic    vbl_q;
  logic    wr_reload;
  logic    copy_now;
  logic    imm_nxt;
  logic    vbl_nxt;

  assign wr_reload = wr_en && (wr_addr == SEL_RELOAD);
  assign copy_now  = imm_q || (vbl_q && frame_wrap);
  assign imm_nxt   = wr_reload && wr_data[0];
  assign vbl_nxt   = (vbl_q && !frame_wrap) || (wr_reload && wr_data[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q     <= '0;
      live_q    <= '0;
      imm_q     <= 1'b0;
      vbl_q     <= 1'b0;
      enable    <= 1'b0;
      pol_h     <= 1'b0;
      pol_v     <= 1'b0;
      pol_de    <= 1'b0;
      pclk_flip <= 1'b0;
      line_pos  <= '0;
    end else begin
      if (copy_now) live_q <= shd_q;
      imm_q <= imm_nxt;
      vbl_q <= vbl_nxt;
      if (wr_en) begin
        case (wr_addr)
          SEL_SYNC:   begin shd_q.h_sync <= h_field(wr_data); shd_q.v_sync <= v_field(wr_data); end
          SEL_BPORCH: begin shd_q.h_bp   <= h_field(wr_data); shd_q.v_bp   <= v_field(wr_data); end
          SEL_ACTIVE: begin shd_q.h_act  <= h_field(wr_data); shd_q.v_act  <= v_field(wr_data); end
          SEL_TOTAL:  begin shd_q.h_tot  <= h_field(wr_data); shd_q.v_tot  <= v_field(wr_data); end
          SEL_CTRL: begin
            enable    <= wr_data[0];
            pclk_flip <= wr_data[28];
            pol_de    <= wr_data[29];
            pol_v     <= wr_data[30];
            pol_h     <= wr_data[31];
          end
          SEL_LINE: line_pos <= v_field(wr_data);
          default: ;
        endcase
      end
    end
  end

  assign live_tim = live_q;
  assign pending  = imm_q || vbl_q;

  AST_IMM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_q && !(wr_reload && wr_data[0])) |=> !imm_q); // R8
  AST_IMM_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    imm_q |=> (live_q == $past(shd_q))); // R8
  AST_VBL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (vbl_q && !frame_wrap) |=> vbl_q); // R9
  AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !copy_now |=> $stable(live_q)); // R7
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [H_BITS-1:0] h_tot,
  input  logic [V_BITS-1:0] v_tot,
  output logic [H_BITS-1:0] x,
  output logic [V_BITS-1:0] y,
  output logic              frame_wrap
);
  logic line_end;
  logic last_line;

  assign line_end   = enable && (x >= h_tot);
  assign last_line  = y >= v_tot;
  assign frame_wrap = line_end && last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else if (!enable) begin
      x <= '0;
      y <= '0;
    end else if (line_end) begin
      x <= '0;
      y <= last_line ? '0 : y + 1'b1;
    end else begin
      x <= x + 1'b1;
    end
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (x == '0 && y == '0)); // R6
  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (x == '0)); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (y == '0)); // R2
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
(
  input  logic              enable,
  input  timing_t           tim,
  input  logic [H_BITS-1:0] x,
  input  logic [V_BITS-1:0] y,
  input  logic              pol_h,
  input  logic              pol_v,
  input  logic              pol_de,
  input  logic [V_BITS-1:0] line_pos,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              line_irq
);
  logic hs_on;
  logic vs_on;
  logic de_on;

  always_comb begin
    hs_on    = enable && (x <= tim.h_sync);
    vs_on    = enable && (y <= tim.v_sync);
    de_on    = enable && in_span(x, tim.h_bp, tim.h_act)
                      && in_span(widen_v(y), widen_v(tim.v_bp), widen_v(tim.v_act));
    hsync    = pin_level(hs_on, pol_h);
    vsync    = pin_level(vs_on, pol_v);
    de       = pin_level(de_on, pol_de);
    line_irq = enable && (x == '0) && (y == line_pos);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_BITS-1:0] wr_addr,
  input  logic [DATA_BITS-1:0] wr_data,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 de,
  output logic                 pclk_inv,
  output logic [H_BITS-1:0]    pos_x,
  output logic [V_BITS-1:0]    pos_y,
  output logic                 line_irq,
  output logic                 reload_pending
);
  timing_t           live_tim;
  logic              enable;
  logic              pol_h;
  logic              pol_v;
  logic              pol_de;
  logic [V_BITS-1:0] line_pos;
  logic              frame_wrap;

  rtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_wrap(frame_wrap), .live_tim(live_tim), .enable(enable),
    .pol_h(pol_h), .pol_v(pol_v), .pol_de(pol_de), .pclk_flip(pclk_inv),
    .line_pos(line_pos), .pending(reload_pending)
  );

  rtg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .h_tot(live_tim.h_tot), .v_tot(live_tim.v_tot),
    .x(pos_x), .y(pos_y), .frame_wrap(frame_wrap)
  );

  rtg_decode u_dec (
    .enable(enable), .tim(live_tim), .x(pos_x), .y(pos_y),
    .pol_h(pol_h), .pol_v(pol_v), .pol_de(pol_de), .line_pos(line_pos),
    .hsync(hsync), .vsync(vsync), .de(de), .line_irq(line_irq)
  );

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> (pos_x == '0)); // R10
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de, pclk_inv, line_irq, reload_pending;
  logic [11:0] pos_x;
  logic [10:0] pos_y;

  int errors = 0;
  int checks = 0;
  bit compare_on = 1'b0;

  // reference model: index 0..3 horizontal sync/bp/act/tot, 4..7 vertical
  int m_shd[8];
  int m_live[8];
  int m_x = 0, m_y = 0, m_line = 0;
  bit m_en = 0, m_ph = 0, m_pv = 0, m_pd = 0, m_pc = 0, m_imm = 0, m_vbl = 0;

  always #5 clk = ~clk;

  raster_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk_inv(pclk_inv),
    .pos_x(pos_x), .pos_y(pos_y), .line_irq(line_irq), .reload_pending(reload_pending)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit lvl(input bit on, input bit hi);
    return hi ? on : !on;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_shd[i] = 0; m_live[i] = 0; end
      m_x = 0; m_y = 0; m_line = 0;
      m_en = 0; m_ph = 0; m_pv = 0; m_pd = 0; m_pc = 0; m_imm = 0; m_vbl = 0;
    end else begin
      bit wrapf;
      bit rl;
      wrapf = m_en && m_x >= m_live[3] && m_y >= m_live[7];
      if (!m_en) begin m_x = 0; m_y = 0; end
      else if (m_x >= m_live[3]) begin m_x = 0; m_y = (m_y >= m_live[7]) ? 0 : m_y + 1; end
      else m_x = m_x + 1;
      if (m_imm || (m_vbl && wrapf)) for (int i = 0; i < 8; i++) m_live[i] = m_shd[i];
      rl = wr_en && wr_addr == 3'd5;
      m_imm = rl && wr_data[0];
      m_vbl = (m_vbl && !wrapf) || (rl && wr_data[1]);
      if (wr_en) begin
        if (wr_addr <= 3'd3) begin
          m_shd[wr_addr] = int'(wr_data[27:16]);
          m_shd[wr_addr + 4] = int'(wr_data[10:0]);
        end else if (wr_addr == 3'd4) begin
          m_en = wr_data[0]; m_pc = wr_data[28]; m_pd = wr_data[29];
          m_pv = wr_data[30]; m_ph = wr_data[31];
        end else if (wr_addr == 3'd6) m_line = int'(wr_data[10:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      bit hs, vs, dd, irq;
      hs  = lvl(m_en && m_x <= m_live[0], m_ph);
      vs  = lvl(m_en && m_y <= m_live[4], m_pv);
      dd  = lvl(m_en && m_x > m_live[1] && m_x <= m_live[2] && m_y > m_live[5] && m_y <= m_live[6], m_pd);
      irq = m_en && m_x == 0 && m_y == m_line;
      chk(int'(pos_x) == m_x && int'(pos_y) == m_y, "R2 position", int'(pos_x) * 10000 + int'(pos_y), m_x * 10000 + m_y);
      chk(hsync == hs && vsync == vs, "R3/R5 sync", {hsync, vsync}, {hs, vs});
      chk(de == dd, "R4 de", de, dd);
      chk(pclk_inv == m_pc, "R5 pclk_inv", pclk_inv, m_pc);
      chk(line_irq == irq, "R10 line_irq", line_irq, irq);
      chk(reload_pending == (m_imm || m_vbl), "R8/R9 pending", reload_pending, m_imm || m_vbl);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_addr = a[2:0]; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] pack(input int h, input int v);
    return {4'b0, h[11:0], 5'b0, v[10:0]};
  endfunction

  task automatic load_timing(input int hs, input int hb, input int ha, input int ht,
                             input int vs, input int vb, input int va, input int vt);
    wr(0, pack(hs, vs)); wr(1, pack(hb, vb)); wr(2, pack(ha, va)); wr(3, pack(ht, vt));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pos_x == 0 && pos_y == 0, "R1 counters", int'(pos_x), 0);
    chk(hsync && vsync && de && !line_irq && !reload_pending && !pclk_inv, "R1 levels",
        {hsync, vsync, de, line_irq, reload_pending, pclk_inv}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pos_x == 0 && pos_y == 0 && !reload_pending, "R1 after release", int'(pos_x), 0);
    compare_on = 1'b1;

    // R7: enable with live timing zero, write shadow only
    wr(4, 32'h0000_0001);
    load_timing(1, 3, 8, 10, 0, 1, 4, 5);
    repeat (4) @(negedge clk);
    chk(pos_x == 0, "R7 shadow not live", int'(pos_x), 0);

    // R8: immediate reload
    wr(5, 32'h1);
    chk(reload_pending == 1'b1, "R8 pending set", reload_pending, 1);
    @(negedge clk);
    chk(reload_pending == 1'b0, "R8 self clear", reload_pending, 0);
    @(negedge clk);
    chk(pos_x == 1, "R8 live copied", int'(pos_x), 1);

    // R11: horizontal total seen as wrap value
    begin
      int mx = 0;
      repeat (40) begin @(negedge clk); if (int'(pos_x) > mx) mx = int'(pos_x); end
      chk(mx == 10, "R11 h total field", mx, 10);
    end

    // R10 and R5: line irq on line 3, active-high polarities
    wr(6, 32'd3);
    wr(4, 32'hF000_0001);
    repeat (150) @(negedge clk);

    // R9: frame-wrap reload
    load_timing(0, 2, 5, 6, 1, 2, 3, 4);
    wr(5, 32'h2);
    @(negedge clk);
    chk(reload_pending == 1'b1 || (pos_x == 0 && pos_y == 0), "R9 waits", reload_pending, 1);
    begin
      int n = 0;
      while (reload_pending && n < 400) begin @(negedge clk); n++; end
      chk(pos_x == 0 && pos_y == 0, "R9 copy at wrap", int'(pos_x) + int'(pos_y), 0);
    end
    repeat (60) @(negedge clk);

    // R6: disable holds counters and inactive levels
    wr(4, 32'hA000_0000);
    repeat (3) @(negedge clk);
    chk(pos_x == 0 && pos_y == 0, "R6 counters held", int'(pos_x) + int'(pos_y), 0);
    chk(hsync == 1'b0 && vsync == 1'b1 && de == 1'b0 && !line_irq, "R6 inactive",
        {hsync, vsync, de, line_irq}, 4'b0100);

    // random configurations
    for (int k = 0; k < 30; k++) begin
      int hs, hb, ha, ht, vs, vb, va, vt;
      hs = $urandom % 3; hb = hs + 1 + $urandom % 3; ha = hb + 1 + $urandom % 4; ht = ha + 1 + $urandom % 3;
      vs = $urandom % 2; vb = vs + 1 + $urandom % 2; va = vb + 1 + $urandom % 3; vt = va + 1 + $urandom % 2;
      load_timing(hs, hb, ha, ht, vs, vb, va, vt);
      wr(6, pack(0, va + 1));
      wr(4, {$urandom % 16, 27'b0, 1'b1} & 32'hF000_0001);
      wr(5, ($urandom % 2) ? 32'h1 : 32'h2);
      repeat (2 * (ht + 1) * (vt + 1) + 20) @(negedge clk);
      if (k % 7 == 3) begin wr(4, 32'h0); repeat (3) @(negedge clk); end
    end

    compare_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule